// File: doc/BRIEF.md
# Event Latch Bank

This block is a bus slave that captures short events from surrounding hardware into a row of sticky flags. Software can then inspect and dismiss those flags. Each event input is brought into the clock domain and turned into a one-cycle pulse on its rising edge. That pulse sets the matching flag, and the flag stays set until software clears it.

Software sees the flags through three bus addresses. One address reports all flags at once. A second address clears only the flags chosen by the written data. A third address forces chosen flags on. Software never writes back a whole copy of the register, so an event that lands while software is dismissing a different flag cannot be erased by mistake. If a clear and a new event hit the same flag in the same cycle, the event is kept.

The bus handshake is the common cycle/strobe/write-enable scheme with a registered acknowledge.

Top module: `evl_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, the acknowledge and read data are 0, and a status read after reset returns 0.
- R2: A rising edge on event input bit i sets flag i. The flag stays set after the input falls. A read with address 0 (status) returns flag i on data bit i.
- R3: A write to address 1 (clear) clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R4: A write to address 2 (set) sets each flag whose data bit is 1 and leaves the other flags unchanged.
- R5: If an event pulse and a clear write hit the same flag at the same clock edge, the flag ends up set.
- R6: Nothing is accepted unless cycle and strobe are both high. A strobe without cycle, or a cycle without strobe, neither acknowledges nor changes any flag.
- R7: An access accepted at clock edge k raises the acknowledge after edge k for exactly one cycle. If cycle and strobe stay high, the next access is accepted at edge k+2.
- R8: Read data is 0 whenever the acknowledge is low. A read of address 1, 2 or 3 returns 0 with the acknowledge.
- R9: A write to address 0 or address 3 changes no flag.
- R10: An event input held high sets its flag only once. If that flag is cleared while the input stays high, it stays clear until the input falls and rises again.
- R11: An event input first sampled high at edge k sets its flag at edge k+2. A status read accepted at edge k+2 therefore still returns the flag clear, and a read accepted later returns it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_cyc_i | input | 1 | Bus cycle in progress |
| bus_stb_i | input | 1 | Strobe for this slave |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | 2 | 0 status, 1 clear, 2 set, 3 unused |
| bus_dat_i | input | NUM_EVT | Write data |
| bus_dat_o | output | NUM_EVT | Read data, 0 when not acknowledging a status read |
| bus_ack_o | output | 1 | Access acknowledge, one cycle |
| evt_i | input | NUM_EVT | Asynchronous event inputs |

## Verification
The bench builds the block with its defaults: eight flags and a two-stage synchroniser. This lets a fixed byte-wide model exercise every flag position and all four address codes, including the unused code. With two synchroniser stages, the bench can line up an event pulse with a clear write at the same edge and can observe the exact edge at which a flag appears. A behavioural model runs beside the design and is compared on every cycle. Directed reads with literal expected values back it up.

// File: rtl/evl_pkg.sv
package evl_pkg;

    localparam int EVL_ADDR_W = 2;

    typedef enum logic [EVL_ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_SET    = 2'd2,
        REG_SPARE  = 2'd3
    } evl_reg_e;

    typedef struct packed {
        logic take;
        logic rd_status;
        logic clr_en;
        logic set_en;
    } evl_cmd_t;

    // Decode one bus cycle; busy blocks a second accept while ack is high.
    function automatic evl_cmd_t evl_decode(
        input logic                  cyc,
        input logic                  stb,
        input logic                  we,
        input logic [EVL_ADDR_W-1:0] adr,
        input logic                  busy
    );
        evl_cmd_t c;
        c.take      = cyc & stb & ~busy;
        c.rd_status = c.take & ~we & (adr == REG_STATUS);
        c.clr_en    = c.take &  we & (adr == REG_CLEAR);
        c.set_en    = c.take &  we & (adr == REG_SET);
        return c;
    endfunction

endpackage

// File: rtl/evl_sync.sv
module evl_sync #(
    parameter int NUM_EVT = 8,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic [NUM_EVT-1:0] pulse_o
);

    localparam int CHAIN_W = STAGES + 1;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
        logic [CHAIN_W-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[CHAIN_W-2:0], evt_i[g]};
        end

        // last synchronised sample high, the one before it low
        assign pulse_o[g] = chain[STAGES-1] & ~chain[STAGES];
    end

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
        (|pulse_o) |=> ((pulse_o & $past(pulse_o)) == '0));

endmodule

// File: rtl/evl_bus.sv
module evl_bus
    import evl_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cyc_i,
    input  logic                  stb_i,
    input  logic                  we_i,
    input  logic [EVL_ADDR_W-1:0] adr_i,
    input  logic [NUM_EVT-1:0]    dat_i,
    input  logic [NUM_EVT-1:0]    lat_i,
    output logic [NUM_EVT-1:0]    clr_mask_o,
    output logic [NUM_EVT-1:0]    set_mask_o,
    output logic [NUM_EVT-1:0]    dat_o,
    output logic                  ack_o
);

    evl_cmd_t cmd;

    always_comb begin
        cmd        = evl_decode(cyc_i, stb_i, we_i, adr_i, ack_o);
        clr_mask_o = cmd.clr_en ? dat_i : '1;
        set_mask_o = cmd.set_en ? dat_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o <= 1'b0;
            dat_o <= '0;
        end else begin
            ack_o <= cmd.take;
            dat_o <= cmd.rd_status ? lat_i : '0;
        end
    end

    a_r6_no_req_no_ack: assert property (@(posedge clk) disable iff (rst)
        !(cyc_i && stb_i) |=> !ack_o);
    a_r7_ack_from_req: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(cyc_i && stb_i));
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !ack_o |-> (dat_o == '0));

endmodule

// File: rtl/evl_latch.sv
module evl_latch #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] clr_mask_i,
    input  logic [NUM_EVT-1:0] set_mask_i,
    input  logic [NUM_EVT-1:0] pulse_i,
    output logic [NUM_EVT-1:0] lat_o
);

    always_ff @(posedge clk) begin
        if (rst) lat_o <= '0;
        else     lat_o <= (lat_o & clr_mask_i) | set_mask_i | pulse_i;
    end

    a_r3_clear_only_selected: assert property (@(posedge clk) disable iff (rst)
        ((lat_o ^ $past(lat_o)) & $past(clr_mask_i) & ~$past(set_mask_i)
            & ~$past(pulse_i)) == '0);
    a_r4_set_forces: assert property (@(posedge clk) disable iff (rst)
        (|set_mask_i) |=> ((lat_o & $past(set_mask_i)) == $past(set_mask_i)));
    a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
        (|pulse_i) |=> ((lat_o & $past(pulse_i)) == $past(pulse_i)));

endmodule

// File: rtl/evl_bank.sv
module evl_bank
    import evl_pkg::*;
#(
    parameter int NUM_EVT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  bus_cyc_i,
    input  logic                  bus_stb_i,
    input  logic                  bus_we_i,
    input  logic [EVL_ADDR_W-1:0] bus_adr_i,
    input  logic [NUM_EVT-1:0]    bus_dat_i,
    output logic [NUM_EVT-1:0]    bus_dat_o,
    output logic                  bus_ack_o,
    input  logic [NUM_EVT-1:0]    evt_i
);

    logic [NUM_EVT-1:0] pulse;
    logic [NUM_EVT-1:0] lat;
    logic [NUM_EVT-1:0] clr_mask;
    logic [NUM_EVT-1:0] set_mask;

    evl_sync #(.NUM_EVT(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_i),
        .rst     (rst_i),
        .evt_i   (evt_i),
        .pulse_o (pulse)
    );

    evl_bus #(.NUM_EVT(NUM_EVT)) u_bus (
        .clk        (clk_i),
        .rst        (rst_i),
        .cyc_i      (bus_cyc_i),
        .stb_i      (bus_stb_i),
        .we_i       (bus_we_i),
        .adr_i      (bus_adr_i),
        .dat_i      (bus_dat_i),
        .lat_i      (lat),
        .clr_mask_o (clr_mask),
        .set_mask_o (set_mask),
        .dat_o      (bus_dat_o),
        .ack_o      (bus_ack_o)
    );

    evl_latch #(.NUM_EVT(NUM_EVT)) u_latch (
        .clk        (clk_i),
        .rst        (rst_i),
        .clr_mask_i (clr_mask),
        .set_mask_i (set_mask),
        .pulse_i    (pulse),
        .lat_o      (lat)
    );

endmodule

// File: tb/sim_evl_bank.sv
module sim_evl_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cyc = 1'b0;
    logic         stb = 1'b0;
    logic         we  = 1'b0;
    logic [1:0]   adr = 2'd0;
    logic [N-1:0] wdat = '0;
    logic [N-1:0] evt  = '0;
    logic [N-1:0] rdat;
    logic         ack;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [N-1:0] m_lat = '0;
    logic [N-1:0] m_dat = '0;
    logic         m_ack = 1'b0;
    logic [N-1:0] h1 = '0, h2 = '0, h3 = '0;

    evl_bank #(.NUM_EVT(N), .SYNC_STAGES(2)) u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .bus_cyc_i (cyc),
        .bus_stb_i (stb),
        .bus_we_i  (we),
        .bus_adr_i (adr),
        .bus_dat_i (wdat),
        .bus_dat_o (rdat),
        .bus_ack_o (ack),
        .evt_i     (evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [N-1:0] act,
                         input logic [N-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
    endtask

    // Advance the model over the coming edge, then compare after it.
    task automatic step(input string req);
        logic         acc;
        logic [N-1:0] pulse;
        logic [N-1:0] nlat;
        if (rst) begin
            m_lat = '0; m_dat = '0; m_ack = 1'b0;
            h1 = '0; h2 = '0; h3 = '0;
        end else begin
            acc   = cyc & stb & ~m_ack;
            pulse = h2 & ~h3;
            nlat  = m_lat;
            if (acc && we && adr == 2'd1) nlat = nlat & wdat;
            if (acc && we && adr == 2'd2) nlat = nlat | wdat;
            nlat  = nlat | pulse;
            m_dat = (acc && !we && adr == 2'd0) ? m_lat : '0;
            m_ack = acc;
            m_lat = nlat;
            h3 = h2; h2 = h1; h1 = evt;
        end
        @(negedge clk);
        check(req, {7'd0, ack}, {7'd0, m_ack}, "model ack");
        check(req, rdat, m_dat, "model data");
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    task automatic access(input logic w, input logic [1:0] a,
                          input logic [N-1:0] d, input string req,
                          output logic [N-1:0] rd);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
        step(req);
        check(req, {7'd0, ack}, 8'd1, "access ack");
        rd = rdat;
        cyc = 1'b0; stb = 1'b0; we = 1'b0; wdat = '0;
        step(req);
    endtask

    task automatic read_exp(input logic [1:0] a, input logic [N-1:0] exp,
                            input string req);
        logic [N-1:0] rd;
        access(1'b0, a, '0, req, rd);
        check(req, rd, exp, "read value");
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d,
                      input string req);
        logic [N-1:0] rd;
        access(1'b1, a, d, req, rd);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        idle(3, "R1");
        check("R1", {7'd0, ack}, 8'd0, "ack in reset");
        check("R1", rdat, 8'h00, "data in reset");
        rst = 1'b0;
        step("R1");
        check("R1", {7'd0, ack}, 8'd0, "ack after reset");
        read_exp(2'd0, 8'h00, "R1");

        // R2: short pulses on bits 0 and 2 are captured and held
        evt = 8'h05; step("R2");
        evt = 8'h00; idle(4, "R2");
        read_exp(2'd0, 8'h05, "R2");

        // R3: zeros clear, ones keep
        wr(2'd1, 8'hFE, "R3");
        read_exp(2'd0, 8'h04, "R3");
        wr(2'd1, 8'hFF, "R3");
        read_exp(2'd0, 8'h04, "R3");

        // R4: ones set, zeros keep
        wr(2'd2, 8'h90, "R4");
        read_exp(2'd0, 8'h94, "R4");
        wr(2'd2, 8'h00, "R4");
        read_exp(2'd0, 8'h94, "R4");

        // R9: writes to status and spare addresses do nothing
        wr(2'd0, 8'h00, "R9");
        read_exp(2'd0, 8'h94, "R9");
        wr(2'd3, 8'h00, "R9");
        read_exp(2'd0, 8'h94, "R9");

        // R8: non-status reads return zero
        read_exp(2'd1, 8'h00, "R8");
        read_exp(2'd2, 8'h00, "R8");
        read_exp(2'd3, 8'h00, "R8");

        // R6: incomplete handshakes are ignored
        cyc = 1'b0; stb = 1'b1; we = 1'b1; adr = 2'd2; wdat = 8'hFF;
        idle(2, "R6");
        check("R6", {7'd0, ack}, 8'd0, "stb only ack");
        cyc = 1'b1; stb = 1'b0; adr = 2'd1; wdat = 8'h00;
        idle(2, "R6");
        check("R6", {7'd0, ack}, 8'd0, "cyc only ack");
        cyc = 1'b0; we = 1'b0; wdat = '0;
        step("R6");
        read_exp(2'd0, 8'h94, "R6");

        // R7: held strobe gives alternating one-cycle acks
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 2'd0;
        step("R7"); check("R7", {7'd0, ack}, 8'd1, "ack 1st");
        step("R7"); check("R7", {7'd0, ack}, 8'd0, "ack gap");
        check("R8", rdat, 8'h00, "data while ack low");
        step("R7"); check("R7", {7'd0, ack}, 8'd1, "ack 2nd");
        check("R7", rdat, 8'h94, "data 2nd");
        cyc = 1'b0; stb = 1'b0;
        step("R7"); check("R7", {7'd0, ack}, 8'd0, "ack released");

        // R5: event pulse and clear of all bits land on the same edge
        evt = 8'h08;
        idle(2, "R5");
        wr(2'd1, 8'h00, "R5");
        read_exp(2'd0, 8'h08, "R5");
        evt = 8'h00; idle(2, "R5");

        // R10: held input does not re-set a cleared flag
        evt = 8'h02; idle(4, "R10");
        read_exp(2'd0, 8'h0A, "R10");
        wr(2'd1, 8'hFD, "R10");
        idle(3, "R10");
        read_exp(2'd0, 8'h08, "R10");
        evt = 8'h00; idle(2, "R10");
        evt = 8'h02; idle(4, "R10");
        read_exp(2'd0, 8'h0A, "R10");
        evt = 8'h00;

        // R11: latency of the capture path
        wr(2'd1, 8'h00, "R11");
        read_exp(2'd0, 8'h00, "R11");
        evt = 8'h40;
        idle(2, "R11");
        read_exp(2'd0, 8'h00, "R11");
        read_exp(2'd0, 8'h40, "R11");
        evt = 8'h00;
        idle(3, "R11");

        summary();
        $finish;
    end

endmodule